// File: doc/BRIEF.md
# Debounced Switch Event Queue

This block watches a small set of push-switch inputs and turns their settled level changes into a stream of event bytes. Each raw input first passes through a two-flop synchronizer. On every pulse of an external sample strobe, nominally one every 2 ms, the block compares each input with its value at the previous strobe. A per-input stability count rises by a fixed step while the input holds steady and clears whenever it moves. When the count goes beyond a threshold, the sampled value is taken as the new debounced level and the count starts again from zero.

A debounced level that really changes produces one event byte. The high nibble gives the kind of change and the low nibble gives the switch index. Events found on the same strobe are scanned from the lowest index upward and written one per clock into a small circular queue. The queue keeps one slot unused, so with five slots it holds four events; an event that meets a full queue is discarded. A consumer sees the oldest event on the output and removes it with a pop request.

Top module: `switch_event_queue`

## Requirements
- R1: After reset every debounced level is low, the queue is empty, `evt_valid` is 0 and `evt_byte` is 0x00.
- R2: The stability count of an input starts at 0. It rises by 2 at each strobe whose sample equals the previous sample and drops to 0 at a strobe whose sample differs. A strobe that brings the count above 20 loads that sample into the debounced level and clears the count. A change therefore becomes visible on the 12th strobe that sees the new value, and not on the 11th.
- R3: An input that returns to its old value before the 12th strobe leaves its debounced level unchanged and produces no event.
- R4: A debounced rise of switch i queues the byte 0x10+i and a debounced fall queues 0x20+i. The byte 0x00 is the null event.
- R5: Events accepted on the same strobe are queued in ascending switch index.
- R6: The queue holds at most four events. An event that arrives while the queue is full is dropped, and the four events already held are kept in order.
- R7: A pop of an empty queue shows `evt_byte` 0x00 with `evt_valid` 0 and leaves the queue unchanged.
- R8: The read and write positions wrap after the fifth slot, and events keep first-in-first-out order across the wrap.
- R9: An accepted sample equal to the current debounced level produces no event, so a switch held steady never queues a second event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_raw | input | 5 | Raw switch levels, asynchronous |
| sample_stb | input | 1 | One-cycle sample strobe, nominally every 2 ms |
| pop | input | 1 | Remove the oldest event when the queue is not empty |
| sw_level | output | 5 | Debounced switch levels |
| evt_byte | output | 8 | Oldest queued event, or 0x00 when empty |
| evt_valid | output | 1 | Queue holds at least one event |

## Verification
The bench targets the edge of the stability threshold. It checks that a new level is still hidden after 11 strobes and visible after 12. A design with an off-by-one compare, or one that did not clear the count on accept, would move a strobe early or late. A burst of five simultaneous presses fills the queue: a design that used all five slots, or overwrote the oldest entry, would show a fifth event or lose 0x10. Pops on an empty queue, and a glitch released one strobe short of the threshold, would expose a design that moved its read position without data or queued spurious events.

// File: rtl/switch_event_queue.sv
module switch_event_queue #(
  parameter int NSW   = 5,
  parameter int NQ    = 5,
  parameter int STEP  = 2,
  parameter int LIMIT = 20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NSW-1:0] sw_raw,
  input  logic           sample_stb,
  input  logic           pop,
  output logic [NSW-1:0] sw_level,
  output logic [7:0]     evt_byte,
  output logic           evt_valid
);
  localparam int CW = $clog2(LIMIT + STEP + 1);
  localparam int PW = $clog2(NQ);
  localparam int IW = (NSW > 1) ? $clog2(NSW) : 1;

  logic [NSW-1:0] sync_a, sync_b, last_s, pend, pend_rise;
  logic [NSW-1:0] accept, chg, clr;
  logic [CW-1:0]  cnt [NSW];
  logic [CW-1:0]  cnt_inc [NSW];
  logic [7:0]     ring [NQ];
  logic [PW-1:0]  head, tail, head_nx, tail_nx;
  logic [IW-1:0]  sel;
  logic           has_pend, full;
  logic [7:0]     wr_byte;

  always_comb begin
    for (int i = 0; i < NSW; i++) begin
      cnt_inc[i] = (sync_b[i] == last_s[i]) ? cnt[i] + CW'(STEP) : '0;
      accept[i]  = cnt_inc[i] > CW'(LIMIT);
      chg[i]     = accept[i] && (sync_b[i] != sw_level[i]);
    end
  end

  always_comb begin
    sel = '0;
    for (int i = NSW - 1; i >= 0; i--)
      if (pend[i]) sel = IW'(i);
    clr = '0;
    if (has_pend) clr[sel] = 1'b1;
  end

  assign has_pend  = |pend;
  assign head_nx   = (head == PW'(NQ - 1)) ? '0 : head + 1'b1;
  assign tail_nx   = (tail == PW'(NQ - 1)) ? '0 : tail + 1'b1;
  assign full      = (head_nx == tail);
  assign evt_valid = (head != tail);
  assign evt_byte  = evt_valid ? ring[tail] : 8'h00;
  assign wr_byte   = {pend_rise[sel] ? 4'h1 : 4'h2, 4'(sel)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a    <= '0;
      sync_b    <= '0;
      last_s    <= '0;
      sw_level  <= '0;
      pend      <= '0;
      pend_rise <= '0;
      head      <= '0;
      tail      <= '0;
      for (int i = 0; i < NSW; i++) cnt[i] <= '0;
      for (int q = 0; q < NQ; q++) ring[q] <= '0;
    end else begin
      sync_a <= sw_raw;
      sync_b <= sync_a;
      if (sample_stb) begin
        last_s <= sync_b;
        for (int i = 0; i < NSW; i++) begin
          cnt[i] <= accept[i] ? '0 : cnt_inc[i];
          if (accept[i]) sw_level[i] <= sync_b[i];
          if (chg[i]) pend_rise[i] <= sync_b[i];
        end
      end
      pend <= (pend & ~clr) | (sample_stb ? chg : '0);
      if (has_pend && !full) begin
        ring[head] <= wr_byte;
        head       <= head_nx;
      end
      if (pop && evt_valid) tail <= tail_nx;
    end
  end

  a_r4_evt_code: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> ((evt_byte[7:4] == 4'h1) || (evt_byte[7:4] == 4'h2)) && (evt_byte[3:0] < NSW));

  a_r2_level_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(sw_level));

  a_r7_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !evt_valid) |=> $stable(tail));

  a_r8_tail_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && evt_valid) |=> (tail != $past(tail)));

  for (genvar g = 0; g < NSW; g++) begin : g_cnt_chk
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[g] <= CW'(LIMIT));
  end
endmodule

// File: tb/switch_event_queue_tb.sv
module switch_event_queue_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] sw_raw = '0;
  logic       sample_stb = 1'b0;
  logic       pop = 1'b0;
  logic [4:0] sw_level;
  logic [7:0] evt_byte;
  logic       evt_valid;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  switch_event_queue dut_i (
    .clk(clk), .rst_n(rst_n), .sw_raw(sw_raw), .sample_stb(sample_stb),
    .pop(pop), .sw_level(sw_level), .evt_byte(evt_byte), .evt_valid(evt_valid)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic strobes(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) sample_stb = 1'b1;
      @(negedge clk) sample_stb = 1'b0;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic pop_expect(input string req, input int exp_byte, input int exp_valid);
    @(negedge clk);
    chk(req, evt_valid, exp_valid);
    chk(req, evt_byte, exp_byte);
    pop = 1'b1;
    @(negedge clk) pop = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 level", sw_level, 0);
    chk("R1 valid", evt_valid, 0);
    chk("R1 byte", evt_byte, 0);
  endtask

  task automatic t_debounce;
    sw_raw = 5'b00001;
    repeat (4) @(negedge clk);
    strobes(11);
    chk("R2 level after 11", sw_level, 0);
    chk("R2 valid after 11", evt_valid, 0);
    strobes(1);
    chk("R2 level after 12", sw_level, 5'b00001);
    pop_expect("R4 rise sw0", 8'h10, 1);
    chk("R4 empty after pop", evt_valid, 0);
  endtask

  task automatic t_steady;
    strobes(24);
    chk("R9 steady valid", evt_valid, 0);
    chk("R9 steady level", sw_level, 5'b00001);
  endtask

  task automatic t_glitch;
    sw_raw = 5'b00000;
    repeat (4) @(negedge clk);
    strobes(11);
    sw_raw = 5'b00001;
    repeat (4) @(negedge clk);
    strobes(12);
    chk("R3 glitch level", sw_level, 5'b00001);
    chk("R3 glitch valid", evt_valid, 0);
  endtask

  task automatic t_release;
    sw_raw = 5'b00000;
    repeat (4) @(negedge clk);
    strobes(12);
    chk("R4 fall level", sw_level, 0);
    pop_expect("R4 fall sw0", 8'h20, 1);
  endtask

  task automatic t_burst(input logic [4:0] v, input int code);
    sw_raw = v;
    repeat (4) @(negedge clk);
    strobes(12);
    chk("R5 burst level", sw_level, v);
    for (int k = 0; k < 4; k++)
      pop_expect("R5 R6 R8 order", code + k, 1);
    pop_expect("R6 fifth dropped R7 empty pop", 8'h00, 0);
    pop_expect("R7 second empty pop", 8'h00, 0);
  endtask

  task automatic t_after_empty;
    sw_raw = 5'b01000;
    repeat (4) @(negedge clk);
    strobes(12);
    pop_expect("R7 R8 queue intact after empty pops", 8'h13, 1);
    chk("R7 empty again", evt_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_debounce();
    t_steady();
    t_glitch();
    t_release();
    t_burst(5'b11111, 8'h10);
    t_burst(5'b00000, 8'h20);
    t_after_empty();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule